// File: doc/BRIEF.md
# Banked GPIO Port Register Block

This block is the register front end of a general-purpose I/O port with up to 58 pins, reached over a simple 32-bit bus where a write takes effect at the next clock edge and a read returns data in the same cycle. Each pin has a 3-bit function field. Only the output code turns the pin's output driver on. The other codes, including the alternate functions, are stored and read back, but nothing else acts on them.

The output latch of each pin is never written directly. Software writes ones into a set word or a clear word, and zero bits in those words leave their pins alone. The sampled level of every pin passes through a two-stage synchronizer and can be read from a per-bank level word. A 2-bit pull field per pin becomes a pull-up or pull-down request toward the pad.

Pins are grouped in three ways: ten per function word, thirty-two per bank word (set, clear and level), and sixteen per pull word. Software locates a pin's field from its number by those strides.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every function field, pull field and output latch is zero. pin_oe, pin_out, pull_up_req and pull_dn_req are all low, and every register reads zero while pin_in is zero.
- R2: Function words sit at byte offsets 0x00, 0x04 and onward. Pin p uses word p/10, bits (p mod 10)*3 to (p mod 10)*3+2. A written field reads back unchanged and keeps its value until its word is written again.
- R3: Function codes are 0 input, 1 output, 4/5/6/7 alternates 0 to 3, 3 alternate 4 and 2 alternate 5. pin_oe[p] is high exactly when pin p holds code 1.
- R4: Writing a word at 0x1c (pins 0–31) or 0x20 (pins 32–57) sets the output latch of every pin whose bit (p mod 32) is 1. Zero bits change nothing. pin_out[p] shows the latch whatever the function code.
- R5: Writing a word at 0x28 (pins 0–31) or 0x2c (pins 32–57) clears the latch of every pin whose bit is 1. Zero bits change nothing.
- R6: The set and clear words always read as zero.
- R7: The level words at 0x34 (pins 0–31) and 0x38 (pins 32–57) return pin_in at bit p mod 32. A change on pin_in appears in the read data after two rising clock edges.
- R8: Pull words start at 0xe4, with 2 bits per pin and 16 pins per word at bit (p mod 16)*2. Code 1 raises pull_up_req, code 2 raises pull_dn_req, and codes 0 and 3 raise neither. Every code reads back as written.
- R9: Bits and fields for pin numbers 58 and above are ignored on write and read as zero. Examples: function word 0x14 keeps only bits 23:0, and pull word 0xf0 keeps only bits 19:0.
- R10: A write to an offset outside the register groups, or with a nonzero value in address bits 1:0, changes nothing. Such an offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 58 | Raw pin levels, asynchronous |
| pin_out | output | 58 | Output latch per pin |
| pin_oe | output | 58 | Output driver enable per pin |
| pull_up_req | output | 58 | Pull-up request per pin |
| pull_dn_req | output | 58 | Pull-down request per pin |

## Verification
The bench targets the shared boundary word of each grouping. A decoder with a wrong stride or base would read pins 50–57 or 48–57 from the wrong place, and it would let the bits above pin 57 or the top two bits of a function word hold data. The bench also writes every alternate code to confirm the driver stays off. A design that tests a single bit of the field, or the wrong one, would enable the driver for codes 3, 5 or 7. Zero bits in set and clear words must leave latches alone. A read-modify-write implementation would corrupt neighbouring pins there, and the bench checks that the set and clear offsets read zero. The level word is read one edge and two edges after an input change: a one-stage or three-stage synchronizer gives the wrong value at one of these two reads.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int WORD_W        = 32;
  localparam int FSEL_W        = 3;
  localparam int FSEL_PER_WORD = 10;
  localparam int PULL_W        = 2;
  localparam int PULL_PER_WORD = 16;
  localparam int BANK_PINS     = 32;

  // Word indices (byte offset / 4) of each register group
  localparam int FSEL_BASE = 0;
  localparam int SET_BASE  = 7;
  localparam int CLR_BASE  = 10;
  localparam int LEV_BASE  = 13;
  localparam int PULL_BASE = 57;

  typedef enum logic [2:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT5   = 3'd2,
    FN_ALT4   = 3'd3,
    FN_ALT0   = 3'd4,
    FN_ALT1   = 3'd5,
    FN_ALT2   = 3'd6,
    FN_ALT3   = 3'd7
  } pin_fn_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_DOWN = 2'd2,
    PULL_RSVD = 2'd3
  } pull_e;

  function automatic int fsel_word(input int p);
    return p / FSEL_PER_WORD;
  endfunction

  function automatic int fsel_lsb(input int p);
    return (p % FSEL_PER_WORD) * FSEL_W;
  endfunction

  function automatic int bank_word(input int p);
    return p / BANK_PINS;
  endfunction

  function automatic int bank_bit(input int p);
    return p % BANK_PINS;
  endfunction

  function automatic int pull_word(input int p);
    return p / PULL_PER_WORD;
  endfunction

  function automatic int pull_lsb(input int p);
    return (p % PULL_PER_WORD) * PULL_W;
  endfunction

endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 58,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_val,
  output logic [NPINS-1:0]  pin_oe
);

  logic [FSEL_W-1:0] fn_q [NPINS];
  logic [NPINS-1:0]  fsel_wr_hit;
  logic              unused_fsel_bits;

  assign unused_fsel_bits = ^wdata[WORD_W-1:FSEL_PER_WORD*FSEL_W];

  always_comb begin
    for (int p = 0; p < NPINS; p++)
      fsel_wr_hit[p] = wr_en && (idx == IDX_W'(FSEL_BASE + fsel_word(p)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) fn_q[p] <= FN_INPUT;
    end else begin
      for (int p = 0; p < NPINS; p++)
        if (fsel_wr_hit[p]) fn_q[p] <= wdata[fsel_lsb(p) +: FSEL_W];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NPINS; p++)
      if (idx == IDX_W'(FSEL_BASE + fsel_word(p)))
        rd_val[fsel_lsb(p) +: FSEL_W] = fn_q[p];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_oe
    localparam int L = fsel_lsb(p);
    assign pin_oe[p] = (fn_q[p] == FN_OUTPUT);

    AST_OE_ON_OUTPUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel_wr_hit[p] && wdata[L +: FSEL_W] == FN_OUTPUT) |=> pin_oe[p]); // R3
    AST_OE_OFF_OTHER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel_wr_hit[p] && wdata[L +: FSEL_W] != FN_OUTPUT) |=> !pin_oe[p]); // R3
    AST_FSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fsel_wr_hit[p] |=> $stable(fn_q[p])); // R2
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 58,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [NPINS-1:0]  pin_out
);

  logic [NPINS-1:0] set_pulse;
  logic [NPINS-1:0] clr_pulse;
  logic [NPINS-1:0] latch_q;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      set_pulse[p] = wr_en && (idx == IDX_W'(SET_BASE + bank_word(p))) && wdata[bank_bit(p)];
      clr_pulse[p] = wr_en && (idx == IDX_W'(CLR_BASE + bank_word(p))) && wdata[bank_bit(p)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else begin
      for (int p = 0; p < NPINS; p++)
        if (set_pulse[p])      latch_q[p] <= 1'b1;
        else if (clr_pulse[p]) latch_q[p] <= 1'b0;
    end
  end

  assign pin_out = latch_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[p] |=> pin_out[p]); // R4
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse[p] && !set_pulse[p]) |=> !pin_out[p]); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_pulse[p] && !clr_pulse[p]) |=> $stable(pin_out[p])); // R4
  end

endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 58,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NPINS-1:0]  pin_in,
  output logic [WORD_W-1:0] rd_val
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      level_q <= '0;
    end else begin
      meta_q  <= pin_in;
      level_q <= meta_q;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NPINS; p++)
      if (idx == IDX_W'(LEV_BASE + bank_word(p)))
        rd_val[bank_bit(p)] = level_q[p];
  end

  // Edges seen since reset, for the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  AST_LEVEL_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (level_q == $past(pin_in, 2))); // R7

endmodule

// File: rtl/gpio_pull_regs.sv
module gpio_pull_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 58,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_val,
  output logic [NPINS-1:0]  pull_up_req,
  output logic [NPINS-1:0]  pull_dn_req
);

  logic [PULL_W-1:0] pull_q [NPINS];
  logic [NPINS-1:0]  pull_wr_hit;

  always_comb begin
    for (int p = 0; p < NPINS; p++)
      pull_wr_hit[p] = wr_en && (idx == IDX_W'(PULL_BASE + pull_word(p)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) pull_q[p] <= PULL_NONE;
    end else begin
      for (int p = 0; p < NPINS; p++)
        if (pull_wr_hit[p]) pull_q[p] <= wdata[pull_lsb(p) +: PULL_W];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NPINS; p++)
      if (idx == IDX_W'(PULL_BASE + pull_word(p)))
        rd_val[pull_lsb(p) +: PULL_W] = pull_q[p];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_req
    localparam int L = pull_lsb(p);
    assign pull_up_req[p] = (pull_q[p] == PULL_UP);
    assign pull_dn_req[p] = (pull_q[p] == PULL_DOWN);

    AST_PULL_UP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_wr_hit[p] && wdata[L +: PULL_W] == PULL_UP) |=> (pull_up_req[p] && !pull_dn_req[p])); // R8
    AST_PULL_DN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_wr_hit[p] && wdata[L +: PULL_W] == PULL_DOWN) |=> (pull_dn_req[p] && !pull_up_req[p])); // R8
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 58,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_up_req,
  output logic [NPINS-1:0]  pull_dn_req
);

  localparam int IDX_W = ADDR_W - 2;

  logic              aligned;
  logic              wr_ok;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] fsel_rd, lev_rd, pull_rd;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr_en && aligned;
  assign idx     = bus_addr[ADDR_W-1:2];

  gpio_fsel_regs #(.NPINS(NPINS), .IDX_W(IDX_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .idx(idx), .wdata(bus_wdata),
    .rd_val(fsel_rd), .pin_oe(pin_oe)
  );

  gpio_out_latch #(.NPINS(NPINS), .IDX_W(IDX_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .idx(idx), .wdata(bus_wdata),
    .pin_out(pin_out)
  );

  gpio_level_sync #(.NPINS(NPINS), .IDX_W(IDX_W)) u_level (
    .clk(clk), .rst_n(rst_n), .idx(idx), .pin_in(pin_in), .rd_val(lev_rd)
  );

  gpio_pull_regs #(.NPINS(NPINS), .IDX_W(IDX_W)) u_pull (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .idx(idx), .wdata(bus_wdata),
    .rd_val(pull_rd), .pull_up_req(pull_up_req), .pull_dn_req(pull_dn_req)
  );

  // Set and clear words contribute nothing: they read as zero
  assign bus_rdata = aligned ? (fsel_rd | lev_rd | pull_rd) : '0;

  AST_MISALIGNED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (bus_rdata == '0)); // R10
  AST_NO_DRIVE_AND_BOTH_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up_req & pull_dn_req) == '0); // R8

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb_top;

  localparam int NP = 58;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pull_up_req, pull_dn_req;

  always #2 clk = ~clk;

  gpio_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_req(pull_up_req),
    .pull_dn_req(pull_dn_req)
  );

  // Scoreboard item kinds: 0 read data, 1 pin_out, 2 pin_oe, 3 pull up, 4 pull down
  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Reference model kept from the requirements
  logic [2:0] m_fn   [NP];
  logic       m_lat  [NP];
  logic [1:0] m_pull [NP];

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_fn[i] = 3'd0; m_lat[i] = 1'b0; m_pull[i] = 2'd0;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = '0;
    int w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return '0;
    if (w <= 5) begin
      for (int k = 0; k < 10; k++) if (w*10 + k < NP) r[k*3 +: 3] = m_fn[w*10 + k];
    end else if (w == 13 || w == 14) begin
      for (int k = 0; k < 32; k++) if ((w-13)*32 + k < NP) r[k] = pin_in[(w-13)*32 + k];
    end else if (w >= 57 && w <= 60) begin
      for (int k = 0; k < 16; k++) if ((w-57)*16 + k < NP) r[k*2 +: 2] = m_pull[(w-57)*16 + k];
    end
    return r;
  endfunction

  function automatic logic [63:0] m_vec(input int kind);
    logic [63:0] v = '0;
    for (int i = 0; i < NP; i++)
      case (kind)
        1: v[i] = m_lat[i];
        2: v[i] = (m_fn[i] == 3'd1);
        3: v[i] = (m_pull[i] == 2'd1);
        default: v[i] = (m_pull[i] == 2'd2);
      endcase
    return v;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return;
    if (w <= 5) begin
      for (int k = 0; k < 10; k++) if (w*10 + k < NP) m_fn[w*10 + k] = d[k*3 +: 3];
    end else if (w == 7 || w == 8) begin
      for (int k = 0; k < 32; k++) if ((w-7)*32 + k < NP && d[k]) m_lat[(w-7)*32 + k] = 1'b1;
    end else if (w == 10 || w == 11) begin
      for (int k = 0; k < 32; k++) if ((w-10)*32 + k < NP && d[k]) m_lat[(w-10)*32 + k] = 1'b0;
    end else if (w >= 57 && w <= 60) begin
      for (int k = 0; k < 16; k++) if ((w-57)*16 + k < NP) m_pull[(w-57)*16 + k] = d[k*2 +: 2];
    end
  endtask

  task automatic push(input int kind, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b0;
    push(0, {32'd0, exp}, tag);
  endtask

  task automatic rd_model(input logic [7:0] a, input string tag);
    rd_expect(a, m_read(a), tag);
  endtask

  task automatic vec_expect(input string tag);
    @(negedge clk);
    for (int k = 1; k <= 4; k++) push(k, m_vec(k), tag);
  endtask

  // Monitor: compares queued items away from the active edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {32'd0, bus_rdata};
        1: act = 64'(pin_out);
        2: act = 64'(pin_oe);
        3: act = 64'(pull_up_req);
        default: act = 64'(pull_dn_req);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_expect(8'h00, 32'h0, "R1 fsel word 0");
    rd_expect(8'h14, 32'h0, "R1 fsel word 5");
    rd_expect(8'h34, 32'h0, "R1 level bank 0");
    rd_expect(8'he4, 32'h0, "R1 pull word 0");
    vec_expect("R1 pin vectors");

    // R2: field placement, hand-computed value
    bus_write(8'h00, (32'd4 << 0) | (32'd1 << 9) | (32'd7 << 27));
    rd_expect(8'h00, 32'h3800_0204, "R2 pins 0,3,9 fields");
    // R2: distinct patterns in every function word
    for (int w = 0; w < 6; w++)
      bus_write(8'(w*4), 32'h2C6A_F135 ^ (32'h1357_9BDF * w));
    for (int w = 0; w < 6; w++) rd_model(8'(w*4), "R2 fsel readback");
    vec_expect("R3 oe after mixed codes");

    // R3: all outputs in word 1, every alternate code in word 2
    bus_write(8'h04, 32'h0924_9249);
    bus_write(8'h08, (32'd2 << 0) | (32'd3 << 3) | (32'd4 << 6) | (32'd5 << 9) |
                     (32'd6 << 12) | (32'd7 << 15) | (32'd0 << 18) | (32'd3 << 21) |
                     (32'd5 << 24) | (32'd7 << 27));
    vec_expect("R3 oe only for code 1");
    rd_model(8'h04, "R2 word 1 holds");

    // R9: top bits of last function word
    bus_write(8'h14, 32'hFFFF_FFFF);
    rd_expect(8'h14, 32'h00FF_FFFF, "R9 fsel word 5 masked");
    vec_expect("R9 oe after alt3 on 50-57");

    // R4 / R6: set words
    bus_write(8'h1c, 32'hA5A5_A5A5);
    vec_expect("R4 set bank 0");
    rd_expect(8'h1c, 32'h0, "R6 set word reads zero");
    bus_write(8'h1c, 32'h0);
    vec_expect("R4 zero bits no effect");
    bus_write(8'h20, 32'hFFFF_FFFF);
    vec_expect("R4 set bank 1");
    rd_expect(8'h20, 32'h0, "R6 set word 1 reads zero");

    // R5 / R6: clear words
    bus_write(8'h28, 32'h0000_FFFF);
    vec_expect("R5 clear bank 0 low half");
    bus_write(8'h2c, 32'h0300_0001);
    vec_expect("R5 clear pins 32,56,57");
    rd_expect(8'h28, 32'h0, "R6 clear word reads zero");
    bus_write(8'h28, 32'h0);
    vec_expect("R5 zero bits no effect");

    // R7: two-edge synchronizer latency
    @(negedge clk);
    pin_in = 58'h1A5_5AA5_C33C_F00F;
    rd_expect(8'h34, 32'h0, "R7 one edge: old level");
    rd_expect(8'h34, 32'hC33C_F00F, "R7 two edges: bank 0");
    rd_expect(8'h38, 32'h01A5_5AA5, "R7 bank 1");
    @(negedge clk);
    pin_in = '1;
    repeat (2) @(negedge clk);
    rd_expect(8'h38, 32'h03FF_FFFF, "R9 level bank 1 upper bits zero");
    rd_expect(8'h34, 32'hFFFF_FFFF, "R7 bank 0 all ones");

    // R8: pull fields
    bus_write(8'he4, 32'h8000_0039);
    rd_expect(8'he4, 32'h8000_0039, "R8 pull word 0 readback");
    vec_expect("R8 pull requests");
    bus_write(8'hf0, 32'hFFFF_FFFF);
    rd_expect(8'hf0, 32'h000F_FFFF, "R9 pull word 3 masked");
    vec_expect("R8 code 3 requests nothing");
    bus_write(8'hf0, 32'h5555_5555);
    rd_expect(8'hf0, 32'h0005_5555, "R8 pull-up on 48-57");
    vec_expect("R8 pull-up vector");
    bus_write(8'he8, 32'hAAAA_AAAA);
    rd_model(8'he8, "R8 pull word 1 readback");
    vec_expect("R8 pull-down vector");

    // R10: unmapped and misaligned accesses
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_write(8'hfc, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'hFFFF_FFFF);
    bus_write(8'h1d, 32'hFFFF_FFFF);
    rd_expect(8'h18, 32'h0, "R10 gap reads zero");
    rd_expect(8'h40, 32'h0, "R10 offset 0x40 reads zero");
    rd_expect(8'hfc, 32'h0, "R10 offset 0xfc reads zero");
    rd_expect(8'h01, 32'h0, "R10 misaligned reads zero");
    rd_model(8'h00, "R10 fsel word 0 untouched");
    vec_expect("R10 pins untouched");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule